// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Sequencer

This block sits between a clocked request bus and an asynchronous static RAM with a 15-bit address, an 8-bit common data bus and active-low select, write and output-enable strobes. It takes one read or write request at a time. It then produces the strobe, address and data-driver waveforms that the memory's timing limits require, captures read data, and pulses a completion flag.

Each access walks through the phases setup, strobe, recover and turnaround. The length of each phase comes from a nanosecond limit of the memory, converted to clock cycles by rounding up, with a floor of one cycle. The clock period and the speed grade (fast or slow) are parameters. Writes are strobed by the write line while output enable stays high, so the memory never drives the bus while the controller does. Between accesses the select line is held high, which keeps the memory in standby. Every pin toward the memory comes straight from a flip-flop.

The memory data bus is split into a driven value, a driver enable and a sampled input. A pad ring or the parent module joins them into the tri-state pin.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and done are 0, and req_ready is 1.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only while idle. A req_valid pulse while busy starts no access, writes nothing and produces no done.
- R3: mem_we_n is 0 only while mem_cs_n is 0 and mem_oe_n is 1. During a write, mem_dq_oe is 1 for the whole time mem_cs_n is 0.
- R4: A write holds mem_we_n at 0 for ceil(max(pulse, address-to-strobe-rise, data setup)/period) cycles (5 at 10 ns, fast grade). mem_addr and mem_dq_out stay unchanged while the memory is selected.
- R5: mem_dq_oe is never 1 while mem_oe_n is 0.
- R6: A read holds mem_oe_n at 0 for ceil(max(address access, select access, output-enable access)/period) cycles (6 at 10 ns, fast grade). rd_data is sampled on the last edge of that window and equals the last byte written to the address.
- R7: After a read releases mem_cs_n and mem_oe_n, at least ceil(bus release time/period) cycles (2 at 10 ns, fast grade) pass before the controller drives the bus or selects the memory again.
- R8: done is a one-cycle pulse. It rises 2 + strobe-length edges after the accepting edge: 7 for a write and 8 for a read at the defaults. req_ready returns two edges after done.
- R9: Every phase length is ceil(limit_ns / CLK_PERIOD_NS) with a minimum of 1. The fast grade uses 40/50/25 ns for a write and 55/55/30 ns for a read, with a 20 ns release. The slow grade uses 50/65/30, 70/70/35 and 25 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Registered read byte |
| mem_addr | output | 15 | Address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Byte sampled from the data bus |

## Verification
At the defaults, done is due exactly 7 edges after a write is accepted and 8 edges after a read is accepted. The scoreboard records the accepting edge when it queues an expected item, and the monitor compares the edge count at done against that. The memory model checks write pulse, data setup and turnaround in nanoseconds at each strobe edge. It returns a poison byte whenever a read is sampled before the access times have passed, so a capture on the wrong cycle shows up as a data mismatch. All outputs are sampled on the falling edge, half a cycle after the registers change.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER,
        ST_TURN
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_PARKED = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    // Round a nanosecond limit up to whole clocks, never below one clock.
    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period);
        int unsigned q;
        q = (ns + period - 1) / period;
        return (q < 1) ? 1 : q;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // Counter never wraps below zero
    assert_timer_floor_R9: assert property (@(posedge clk) disable iff (rst)
        (!load && expired) |=> expired);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int SETUP_C = 1,
    parameter int WSTB_C  = 5,
    parameter int RSTB_C  = 6,
    parameter int REC_C   = 1,
    parameter int TURN_C  = 2,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    output logic idle,
    output logic op_wr,
    output logic ev_accept,
    output logic ev_strobe,
    output logic ev_recover,
    output logic ev_turn
);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_C - 1);
    localparam logic [CNT_W-1:0] LD_WSTB  = CNT_W'(WSTB_C - 1);
    localparam logic [CNT_W-1:0] LD_RSTB  = CNT_W'(RSTB_C - 1);
    localparam logic [CNT_W-1:0] LD_REC   = CNT_W'(REC_C - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_C - 1);

    seq_state_t       state_q, state_d;
    logic             op_wr_q;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        ev_accept  = 1'b0;
        ev_strobe  = 1'b0;
        ev_recover = 1'b0;
        ev_turn    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                ev_accept = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = LD_SETUP;
                state_d   = ST_SETUP;
            end
            ST_SETUP: if (tmr_expired) begin
                ev_strobe = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = op_wr_q ? LD_WSTB : LD_RSTB;
                state_d   = ST_STROBE;
            end
            ST_STROBE: if (tmr_expired) begin
                ev_recover = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = LD_REC;
                state_d    = ST_RECOVER;
            end
            ST_RECOVER: if (tmr_expired) begin
                ev_turn  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = LD_TURN;
                state_d  = ST_TURN;
            end
            ST_TURN: if (tmr_expired) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_wr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ev_accept) op_wr_q <= req_write;
        end
    end

    assign idle  = (state_q == ST_IDLE);
    assign op_wr = op_wr_q;

    // Access kind cannot change mid-access
    assert_op_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (!idle && !$past(idle)) |-> $stable(op_wr_q));
    // Turnaround always ends in idle
    assert_turn_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TURN && tmr_expired) |=> idle);
endmodule

// File: rtl/sram_pin_regs.sv
`timescale 1ns/1ps
module sram_pin_regs
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_accept,
    input  logic              ev_strobe,
    input  logic              ev_recover,
    input  logic              ev_turn,
    input  logic              op_wr,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output pin_ctl_t          pins,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    pin_ctl_t          pins_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= PINS_PARKED;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ev_accept) begin
                pins_q.cs_n  <= 1'b0;
                pins_q.dq_oe <= req_write;
                addr_q       <= req_addr;
                wdata_q      <= req_wdata;
            end
            if (ev_strobe) begin
                if (op_wr) pins_q.we_n <= 1'b0;
                else       pins_q.oe_n <= 1'b0;
            end
            if (ev_recover) begin
                if (op_wr) begin
                    pins_q.we_n <= 1'b1;
                end else begin
                    rdata_q     <= mem_dq_in;
                    pins_q.oe_n <= 1'b1;
                    pins_q.cs_n <= 1'b1;
                end
            end
            if (ev_turn) begin
                pins_q.cs_n  <= 1'b1;
                pins_q.dq_oe <= 1'b0;
                done_q       <= 1'b1;
            end
        end
    end

    assign pins       = pins_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rd_data    = rdata_q;
    assign done       = done_q;

    assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.we_n && $past(!pins_q.we_n)) |-> $stable(wdata_q));
    assert_rdata_held_R6: assert property (@(posedge clk) disable iff (rst)
        !pins_q.cs_n |=> (pins_q.cs_n || $stable(rdata_q)));
endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter bit FAST_GRADE    = 1'b1,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Memory limits in ns for the chosen grade
    localparam int unsigned NS_ADDR_SU = 0;
    localparam int unsigned NS_WPULSE  = FAST_GRADE ? 40 : 50;
    localparam int unsigned NS_A_TO_WR = FAST_GRADE ? 50 : 65;
    localparam int unsigned NS_D_SU    = FAST_GRADE ? 25 : 30;
    localparam int unsigned NS_WREC    = 0;
    localparam int unsigned NS_ACC_A   = FAST_GRADE ? 55 : 70;
    localparam int unsigned NS_ACC_S   = FAST_GRADE ? 55 : 70;
    localparam int unsigned NS_ACC_OE  = FAST_GRADE ? 30 : 35;
    localparam int unsigned NS_RELEASE = FAST_GRADE ? 20 : 25;

    localparam int SETUP_C = int'(ns_to_clk(NS_ADDR_SU, CLK_PERIOD_NS));
    localparam int WSTB_C  = int'(ns_to_clk(max3(NS_WPULSE, NS_A_TO_WR, NS_D_SU), CLK_PERIOD_NS));
    localparam int RSTB_C  = int'(ns_to_clk(max3(NS_ACC_A, NS_ACC_S, NS_ACC_OE), CLK_PERIOD_NS));
    localparam int REC_C   = int'(ns_to_clk(NS_WREC, CLK_PERIOD_NS));
    localparam int TURN_C  = int'(ns_to_clk(NS_RELEASE, CLK_PERIOD_NS));
    localparam int MAX_C   = int'(max3(max3(SETUP_C, WSTB_C, RSTB_C), REC_C, TURN_C));
    localparam int CNT_W   = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    logic     idle, op_wr;
    logic     ev_accept, ev_strobe, ev_recover, ev_turn;
    pin_ctl_t pins;

    sram_seq_fsm #(
        .SETUP_C (SETUP_C),
        .WSTB_C  (WSTB_C),
        .RSTB_C  (RSTB_C),
        .REC_C   (REC_C),
        .TURN_C  (TURN_C),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .idle       (idle),
        .op_wr      (op_wr),
        .ev_accept  (ev_accept),
        .ev_strobe  (ev_strobe),
        .ev_recover (ev_recover),
        .ev_turn    (ev_turn)
    );

    sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .ev_accept  (ev_accept),
        .ev_strobe  (ev_strobe),
        .ev_recover (ev_recover),
        .ev_turn    (ev_turn),
        .op_wr      (op_wr),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .pins       (pins),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data),
        .done       (done)
    );

    assign req_ready = idle;
    assign mem_cs_n  = pins.cs_n;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.dq_oe;

    assert_write_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));
    assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_select_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n) |-> $past(req_valid && req_ready));
    assert_idle_parked_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
module async_sram_ctrl_bench;
    localparam int    WR_LAT  = 7;    // accept edge to done, write (R8)
    localparam int    RD_LAT  = 8;    // accept edge to done, read (R8)
    localparam logic [7:0] BLANK  = 8'h5A;
    localparam logic [7:0] POISON = 8'hEE;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_sram_ctrl u_async_sram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem [int];
    logic       p_cs = 1, p_we = 1, p_oe = 1, p_dqoe = 0;
    logic [14:0] p_addr = '0;
    logic [7:0]  p_dout = '0;
    time t_addr = 0, t_cs = 0, t_oe = 0, t_we = 0, t_data = 0, t_rel = 0;

    initial mem_dq_in = POISON;

    always @(negedge clk) begin
        time e, nx;
        e  = $time - 5;
        nx = $time + 5;
        if (!rst) begin
            // Write commits on the first of strobe or select rising (R4)
            if (!p_we && (mem_we_n || mem_cs_n)) begin
                check((e - t_we) >= 40, "R4 write pulse ns", int'(e - t_we), 40);
                check((e - t_data) >= 25, "R4 data setup ns", int'(e - t_data), 25);
                check((e - t_addr) >= 50 && t_addr <= t_we, "R4 address setup ns",
                      int'(e - t_addr), 50);
                mem[int'(p_addr)] = p_dout;
            end
            if (mem_dq_oe && !p_dqoe)
                check((e - t_rel) >= 20, "R7 bus turnaround ns", int'(e - t_rel), 20);
            if (!mem_cs_n && !p_cs)
                check(mem_addr == p_addr, "R4 address held while selected",
                      int'(mem_addr), int'(p_addr));
            if (mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n)
                check(1'b0, "R5 bus contention", 1, 0);
        end
        if (mem_addr != p_addr)            t_addr = e;
        if (mem_cs_n != p_cs && !mem_cs_n) t_cs   = e;
        if (mem_oe_n != p_oe && !mem_oe_n) t_oe   = e;
        if (mem_we_n != p_we && !mem_we_n) t_we   = e;
        if (mem_dq_out != p_dout || (mem_dq_oe && !p_dqoe)) t_data = e;
        if ((mem_cs_n && !p_cs) || (mem_oe_n && !p_oe)) t_rel = e;
        p_cs = mem_cs_n; p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe;
        p_addr = mem_addr; p_dout = mem_dq_out;
        if (!mem_cs_n && !mem_oe_n && mem_we_n && (nx - t_addr) >= 55 &&
            (nx - t_cs) >= 55 && (nx - t_oe) >= 30)
            mem_dq_in = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : BLANK;
        else
            mem_dq_in = POISON;
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic        wr;
        logic [14:0] addr;
        logic [7:0]  data;
        int          acc;
    } exp_t;
    exp_t       sb_q[$];
    logic [7:0] shadow [int];

    task automatic do_access(input bit wr, input logic [14:0] a, input logic [7:0] d);
        exp_t x;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        x.wr = wr; x.addr = a; x.acc = cyc + 1;
        if (wr) begin
            shadow[int'(a)] = d;
            x.data = d;
        end else begin
            x.data = shadow.exists(int'(a)) ? shadow[int'(a)] : BLANK;
        end
        sb_q.push_back(x);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        exp_t x;
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 done without accepted request", 1, 0);
            end else begin
                x = sb_q.pop_front();
                // R8 and R9: latency follows the ceil(ns/period) phase lengths
                check(cyc == x.acc + (x.wr ? WR_LAT : RD_LAT), "R8 R9 done latency",
                      cyc - x.acc, x.wr ? WR_LAT : RD_LAT);
                if (!x.wr)
                    check(rd_data == x.data, "R6 read data", int'(rd_data), int'(x.data));
            end
        end
    end

    // R8: done lasts one cycle and req_ready returns two edges later
    always @(negedge clk) begin
        if (!rst && done) begin
            @(negedge clk);
            check(!done, "R8 done single cycle", int'(done), 0);
            check(!req_ready, "R8 ready after done+1", int'(req_ready), 0);
            @(negedge clk);
            check(req_ready, "R8 ready after done+2", int'(req_ready), 1);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: parked while reset is asserted
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done,
              "R1 pins in reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, done}, 5'b11100);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", int'(req_ready), 1);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 pins idle", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);

        // R6: unwritten location returns the model's blank value
        do_access(1'b0, 15'h0040, 8'h00);
        // R3, R4: writes at address boundaries and varied data
        do_access(1'b1, 15'h0000, 8'h00);
        do_access(1'b1, 15'h7FFE, 8'hFF);
        do_access(1'b1, 15'h2AAA, 8'hA5);
        do_access(1'b1, 15'h5555, 8'h3C);

        // R2: pulse a request while a write is in flight
        do_access(1'b1, 15'h0100, 8'h81);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h1234; req_wdata = 8'h99;
        @(negedge clk);
        check(!req_ready, "R2 busy while access in flight", int'(req_ready), 0);
        req_valid = 1'b0;

        // R6, R7: read back, alternating with writes to force turnarounds
        do_access(1'b0, 15'h0000, 8'h00);
        do_access(1'b0, 15'h7FFE, 8'h00);
        do_access(1'b1, 15'h2AAA, 8'h5B);
        do_access(1'b0, 15'h2AAA, 8'h00);
        do_access(1'b0, 15'h5555, 8'h00);
        do_access(1'b0, 15'h0100, 8'h00);
        // R2: ignored request must have written nothing
        do_access(1'b0, 15'h1234, 8'h00);

        while (!req_ready || sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2 every request completed once", sb_q.size(), 0);
        check(mem_cs_n, "R1 standby after traffic", int'(mem_cs_n), 1);
        finish_run();
    end
endmodule